// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a down-counting supervision timer for a processor subsystem. Software programs a reload value and a window threshold, chooses whether an expiry raises an interrupt or asks the reset controller for a reset, and then has to refresh the timer at regular intervals. A refresh counts only when a fixed 32-bit key is written to the refresh address, and it loads the counter from the reload register. The six low bits of the reload register are always ones, so at least 64 cycles pass between a refresh and the next expiry.

The window threshold splits each count period into two parts. While the counter is still above the threshold, a refresh is too early. The refresh still reloads the counter, but the timeout action for the current mode also fires. Once the counter has dropped to the threshold or below, a refresh is accepted quietly. A threshold at or above the reload value removes the early part of the period. When the counter reaches zero, it reloads and keeps running. In reset mode it emits a one-cycle request pulse. In interrupt mode it sets a sticky interrupt that software clears through a register write.

Top module: `wdog_window`

## Requirements
- R1: After reset, the reload register (address 0) and the window register (address 1) both read 0xFFFFFFFF. The mode bit (address 2, bit 0) reads 0, which selects reset mode. Both the interrupt output and the reset-request output are low.
- R2: Bits [5:0] of the reload register always read 0x3F, whatever value is written. Bits [31:6] hold the written value.
- R3: When the counter (read at address 5) is non-zero and no refresh occurs, it drops by exactly one each clock cycle.
- R4: Writing exactly 0xAC15DE42 to address 3 is a refresh. On the next cycle the counter holds the reload value.
- R5: A write of any other value to address 3 is ignored. The counter keeps decrementing and no timeout action fires.
- R6: In reset mode (mode bit 0), the cycle after the counter is at zero without a refresh, `rst_req_o` is high for exactly one cycle. The counter reloads on that same cycle, so the pulse appears reload+1 cycles after a refresh.
- R7: In interrupt mode (mode bit 1), the same expiry sets `irq_o` instead. `irq_o` stays high until any write to address 4. Bit 0 of address 4 reads the interrupt state. `rst_req_o` stays low in this mode.
- R8: A refresh while the counter is above the window threshold reloads the counter and also fires the timeout action of the current mode on the next cycle.
- R9: A refresh while the counter is less than or equal to the window threshold reloads the counter and fires no timeout action.
- R10: A refresh in the same cycle that the counter is at zero wins. The counter reloads and no timeout action fires.
- R11: After the interrupt has been cleared, the next expiry of the free-running counter raises `irq_o` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address, used for both write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Sticky timeout interrupt |
| rst_req_o | output | 1 | One-cycle reset-request pulse |

## Verification
The hardest case to reach is a refresh that lands in the one cycle when the counter is at zero (R10). Being one cycle off either way turns it into an ordinary expiry or a permitted refresh. The bench refreshes, reads the counter to pin down its phase, and then waits exactly the reload value in cycles before issuing the key write. Because the counter reloads to the same value on both paths, the only thing that can tell a correct result from an expiry is the absence of a pulse on the following cycle. The threshold case where the counter equals the window value is reached the same way, by counting cycles from a known refresh.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned ADDR_W = 3;

    // Register addresses seen at the block's register port.
    typedef enum logic [ADDR_W-1:0] {
        A_RELOAD = 3'd0,
        A_WINDOW = 3'd1,
        A_CTRL   = 3'd2,
        A_KEY    = 3'd3,
        A_IRQ    = 3'd4,
        A_COUNT  = 3'd5
    } wdt_addr_e;

    // Timeout action selected by control bit 0.
    typedef enum logic {
        MODE_RESET = 1'b0,
        MODE_IRQ   = 1'b1
    } wdt_mode_e;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned    W          = 32,
    parameter int unsigned    FLOOR_BITS = 6,
    parameter logic [W-1:0]   KEY        = 32'hAC15_DE42,
    parameter logic [W-1:0]   RELOAD_RST = '1,
    parameter logic [W-1:0]   WINDOW_RST = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  wdt_addr_e       wr_addr,
    input  logic [W-1:0]    wr_data,
    output logic [W-1:0]    reload_o,
    output logic [W-1:0]    window_o,
    output wdt_mode_e       mode_o,
    output logic            refresh_o,
    output logic            irq_clr_o
);

    localparam logic [W-1:0] FLOOR_MASK = {{(W-FLOOR_BITS){1'b0}}, {FLOOR_BITS{1'b1}}};

    typedef struct packed {
        logic [W-1:0] reload;
        logic [W-1:0] window;
        wdt_mode_e    mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_RELOAD: r_d.reload = wr_data | FLOOR_MASK;
                A_WINDOW: r_d.window = wr_data;
                A_CTRL:   r_d.mode   = wdt_mode_e'(wr_data[0]);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.reload <= RELOAD_RST | FLOOR_MASK;
            r_q.window <= WINDOW_RST;
            r_q.mode   <= MODE_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign reload_o  = r_q.reload;
    assign window_o  = r_q.window;
    assign mode_o    = r_q.mode;
    assign refresh_o = wr_en && (wr_addr == A_KEY) && (wr_data == KEY);
    assign irq_clr_o = wr_en && (wr_addr == A_IRQ);

endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned  W       = 32,
    parameter logic [W-1:0] CNT_RST = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            refresh_i,
    input  logic            irq_clr_i,
    input  logic [W-1:0]    reload_i,
    input  logic [W-1:0]    window_i,
    input  wdt_mode_e       mode_i,
    output logic [W-1:0]    count_o,
    output logic            irq_o,
    output logic            rst_req_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
        logic         rst_req;
    } core_t;

    core_t c_d, c_q;
    logic  expire, early, fire;

    always_comb begin
        c_d    = c_q;
        expire = 1'b0;
        early  = 1'b0;
        if (refresh_i) begin
            // A refresh takes priority over an expiry in the same cycle.
            c_d.cnt = reload_i;
            early   = c_q.cnt > window_i;
        end else if (c_q.cnt == '0) begin
            c_d.cnt = reload_i;
            expire  = 1'b1;
        end else begin
            c_d.cnt = c_q.cnt - 1'b1;
        end
        fire        = expire || early;
        c_d.rst_req = fire && (mode_i == MODE_RESET);
        if (fire && (mode_i == MODE_IRQ)) begin
            c_d.irq = 1'b1;
        end else if (irq_clr_i) begin
            c_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt     <= CNT_RST;
            c_q.irq     <= 1'b0;
            c_q.rst_req <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_o   = c_q.cnt;
    assign irq_o     = c_q.irq;
    assign rst_req_o = c_q.rst_req;

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdt_pkg::*;
#(
    parameter int unsigned  W          = 32,
    parameter int unsigned  FLOOR_BITS = 6,
    parameter logic [W-1:0] KEY        = 32'hAC15_DE42,
    parameter logic [W-1:0] RELOAD_RST = '1,
    parameter logic [W-1:0] WINDOW_RST = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [W-1:0]        wr_data,
    output logic [W-1:0]        rd_data,
    output logic                irq_o,
    output logic                rst_req_o
);

    localparam logic [W-1:0] CNT_RST =
        RELOAD_RST | {{(W-FLOOR_BITS){1'b0}}, {FLOOR_BITS{1'b1}}};

    wdt_addr_e     addr_e;
    logic [W-1:0]  reload_w, window_w, count_w;
    wdt_mode_e     mode_w;
    logic          refresh_w, irq_clr_w;

    assign addr_e = wdt_addr_e'(addr);

    wdt_regs #(
        .W(W), .FLOOR_BITS(FLOOR_BITS), .KEY(KEY),
        .RELOAD_RST(RELOAD_RST), .WINDOW_RST(WINDOW_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr_e),
        .wr_data(wr_data), .reload_o(reload_w), .window_o(window_w),
        .mode_o(mode_w), .refresh_o(refresh_w), .irq_clr_o(irq_clr_w)
    );

    wdt_core #(.W(W), .CNT_RST(CNT_RST)) u_core (
        .clk(clk), .rst_n(rst_n), .refresh_i(refresh_w), .irq_clr_i(irq_clr_w),
        .reload_i(reload_w), .window_i(window_w), .mode_i(mode_w),
        .count_o(count_w), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always_comb begin
        rd_data = '0;
        unique case (addr_e)
            A_RELOAD: rd_data = reload_w;
            A_WINDOW: rd_data = window_w;
            A_CTRL:   rd_data[0] = mode_w;
            A_IRQ:    rd_data[0] = irq_o;
            A_COUNT:  rd_data = count_w;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk
    import wdt_pkg::*;
#(
    parameter int unsigned  W   = 32,
    parameter logic [W-1:0] KEY = 32'hAC15_DE42
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [W-1:0]       wr_data,
    input logic               irq_o,
    input logic               rst_req_o,
    input logic [W-1:0]       cnt,
    input logic [W-1:0]       reload,
    input logic [W-1:0]       window,
    input wdt_mode_e          mode
);

    logic key_hit, clr_hit;
    assign key_hit = wr_en && (addr == 3'd3) && (wr_data == KEY);
    assign clr_hit = wr_en && (addr == 3'd4);

    p_reload_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload[5:0] == 6'h3F);

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) && !key_hit |=> cnt == $past(cnt) - 1'b1);

    p_refresh_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> cnt == $past(reload));

    p_expire_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) && !key_hit && (mode == MODE_RESET) |=> rst_req_o);

    p_reset_mode_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RESET) && !irq_o |=> !irq_o);

    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) && !key_hit && (mode == MODE_IRQ) |=> irq_o);

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && !clr_hit |=> irq_o);

    p_early_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit && (cnt > window) && (mode == MODE_RESET) |=> rst_req_o);

    p_permitted_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit && (cnt <= window) && (mode == MODE_RESET) |=> !rst_req_o);

endmodule

bind wdog_window wdog_window_chk #(.W(W), .KEY(KEY)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irq_o(irq_o), .rst_req_o(rst_req_o), .cnt(count_w), .reload(reload_w),
    .window(window_w), .mode(mode_w)
);

// File: tb/sim_wdog_window.sv
`timescale 1ns/1ps
module sim_wdog_window;

    localparam logic [31:0] KEY = 32'hAC15_DE42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o, rst_req_o;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    wdog_window u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Caller sits at a negedge; returns at the next negedge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count negedges until sig goes high; -1 if not within limit.
    task automatic wait_rise(input bit use_irq, input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if ((use_irq ? irq_o : rst_req_o) === 1'b1) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 reload reset", v, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R1 window reset", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R1 mode reset",   v, 32'd0);
        chk("R1 irq low",    {31'd0, irq_o},     32'd0);
        chk("R1 rst_req low", {31'd0, rst_req_o}, 32'd0);
    endtask

    task automatic t_floor();
        logic [31:0] v;
        wr(3'd0, 32'h1234_5600);
        rd(3'd0, v); chk("R2 floor bits forced", v, 32'h1234_563F);
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R2 zero write reads 3F", v, 32'h0000_003F);
    endtask

    task automatic t_refresh_count();
        logic [31:0] a, b;
        wr(3'd3, KEY);
        rd(3'd5, a); chk("R4 refresh loads reload", a, 32'd63);
        chk("R9 refresh below window quiet", {31'd0, rst_req_o}, 32'd0);
        @(negedge clk);
        rd(3'd5, b); chk("R3 decrement by one", b, 32'd62);
        @(negedge clk);
        rd(3'd5, b); chk("R3 second decrement", b, 32'd61);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        wr(3'd3, KEY);
        wr(3'd3, KEY ^ 32'h1);
        rd(3'd5, v); chk("R5 wrong key no reload", v, 32'd62);
        chk("R5 wrong key no action", {31'd0, rst_req_o}, 32'd0);
    endtask

    task automatic t_reset_timeout();
        int n;
        logic [31:0] v;
        wr(3'd3, KEY);
        wait_rise(1'b0, 200, n);
        chk("R6 pulse after reload+1 cycles", n, 32'd64);
        rd(3'd5, v); chk("R6 counter reloaded", v, 32'd63);
        @(negedge clk);
        chk("R6 pulse one cycle", {31'd0, rst_req_o}, 32'd0);
        rd(3'd5, v); chk("R6 counter keeps running", v, 32'd62);
        chk("R6 no irq in reset mode", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        wr(3'd3, KEY);
        idle(63);
        rd(3'd5, v); chk("R10 counter at zero", v, 32'd0);
        wr(3'd3, KEY);
        chk("R10 refresh beats expiry", {31'd0, rst_req_o}, 32'd0);
        rd(3'd5, v); chk("R10 counter reloaded", v, 32'd63);
    endtask

    task automatic t_window_reset_mode();
        logic [31:0] v;
        wr(3'd1, 32'd10);
        wr(3'd3, KEY);
        chk("R8 early refresh fires pulse", {31'd0, rst_req_o}, 32'd1);
        rd(3'd5, v); chk("R8 early refresh reloads", v, 32'd63);
        idle(53);
        rd(3'd5, v); chk("R9 counter at threshold", v, 32'd10);
        wr(3'd3, KEY);
        chk("R9 refresh at threshold quiet", {31'd0, rst_req_o}, 32'd0);
        rd(3'd5, v); chk("R9 refresh reloads", v, 32'd63);
        idle(60);
        wr(3'd3, KEY);
        chk("R9 refresh below threshold quiet", {31'd0, rst_req_o}, 32'd0);
    endtask

    task automatic t_irq_mode();
        int n;
        logic [31:0] v;
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'd1);
        wr(3'd3, KEY);
        wait_rise(1'b1, 200, n);
        chk("R7 irq after reload+1 cycles", n, 32'd64);
        idle(10);
        chk("R7 irq sticky", {31'd0, irq_o}, 32'd1);
        chk("R7 no reset pulse", {31'd0, rst_req_o}, 32'd0);
        rd(3'd4, v); chk("R7 irq status read", v, 32'd1);
        wr(3'd4, 32'd0);
        chk("R7 irq cleared", {31'd0, irq_o}, 32'd0);
        wait_rise(1'b1, 200, n);
        chk("R11 irq re-raised next expiry", n, 32'd53);
        wr(3'd4, 32'd0);
        wr(3'd1, 32'd10);
        wr(3'd3, KEY);
        chk("R8 early refresh raises irq", {31'd0, irq_o}, 32'd1);
        chk("R8 irq mode no pulse", {31'd0, rst_req_o}, 32'd0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_floor();
        t_refresh_count();
        t_bad_key();
        t_reset_timeout();
        t_same_cycle();
        t_window_reset_mode();
        t_irq_mode();
        done = 1;
        summary();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

endmodule